// File: doc/BRIEF.md
# Selectable-Latency Read Output Stage

This block is the last stage of a synchronous memory's read path. It takes the read word coming out of the array and decides two things each cycle: which value the data pins carry and whether the pin drivers are on. It works in one of two output modes. In flow-through mode the array word goes to the pins in the same cycle. In registered mode it is first caught in a rising-edge output register, which adds one cycle. Measured from the clock edge that captures the address, a first access therefore takes 2 cycles in flow-through mode and 3 in registered mode. Each further burst beat takes one more cycle.

A second, independent strap sets how fast the drivers release the bus after a deselect. With single-cycle release, the drivers switch off in the cycle in which the deselect command leaves the input registers. With dual-cycle release, the deselect travels through the same stage as read data, so in registered mode the bus stays driven for one more full cycle. After a read result appears, the drivers keep presenting that word through idle cycles until a deselect or a write ends the selection. A write turns the drivers off in its own cycle, so the block never drives against incoming write data. The active-low output enable gates the drivers combinationally.

The straps are static configuration. Tying `pipe_en` high and `dcd_en` low gives the power-up default: registered output with single-cycle release. There is no valid/ready handshake. The array cannot be stalled, so every port is a plain level signal, there is no back-pressure, and each read result is presented in its fixed cycle.

Top module: `rdo_stage`

## Requirements
- R1: With `pipe_en`=0 (flow-through), in a cycle with `cmd_rd`=1, `dout` equals `arr_data` of that same cycle, and `drv_en`=1 unless R3 or R6 blocks it.
- R2: With `pipe_en`=1 (registered), the `arr_data` present in a cycle with `cmd_rd`=1 appears on `dout` in the next cycle, with `drv_en`=1 unless R3, R4 or R6 blocks it.
- R3: `oe_n`=1 forces `drv_en`=0 in the same cycle, combinationally, in every mode.
- R4: With `dcd_en`=0 (single-cycle release), `drv_en`=0 in every cycle in which `cmd_desel`=1, in both output modes.
- R5: With `dcd_en`=1 and `pipe_en`=1, a deselect takes effect one cycle later. In the `cmd_desel` cycle the output still follows R2 and R7, and in the next cycle `drv_en`=0. With `dcd_en`=1 and `pipe_en`=0, release timing is the same as in R4.
- R6: `cmd_wr`=1 forces `drv_en`=0 in the same cycle and ends any held selection.
- R7: After a read result has been presented, `drv_en` stays 1 and `dout` holds the last read word through cycles with no command, until a deselect (R4/R5) or a write (R6) takes effect.
- R8: During and after reset, `drv_en`=0 and `dout`=0 until the first read result is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_en | input | 1 | Strap: 1 = registered output, 0 = flow-through |
| dcd_en | input | 1 | Strap: 1 = dual-cycle release, 0 = single-cycle release |
| cmd_rd | input | 1 | Read beat issued from the input registers this cycle |
| cmd_desel | input | 1 | Deselect issued from the input registers this cycle |
| cmd_wr | input | 1 | Write issued from the input registers this cycle |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| arr_data | input | DATA_W | Array read word for the current read command |
| dout | output | DATA_W | Value presented to the data pins |
| drv_en | output | 1 | Data pin driver enable |

## Verification
Results fall due at fixed offsets from the command cycle. In flow-through mode the data and the enable are due in the command's own cycle. In registered mode the data is due one cycle later. Single-cycle release takes effect in the deselect cycle, and dual-cycle release in registered mode takes effect one cycle after it. Write and output-enable effects are due in the same cycle. The bench drives each cycle's inputs on the falling edge and samples both outputs just before the next rising edge. It keeps a per-cycle requirement model that holds the previous cycle's read and deselect flags, so every comparison lands in the cycle where the offset above places the result. All four strap combinations are swept with directed and pseudo-random command streams.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef struct packed {
    logic rd;
    logic desel;
    logic wr;
  } rdo_cmd_t;
endpackage

// File: rtl/rdo_drive_ctl.sv
module rdo_drive_ctl
  import rdo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pipe_en,
  input  logic     dcd_en,
  input  rdo_cmd_t cmd,
  input  logic     oe_n,
  output logic     drv_en
);
  logic rd_q, desel_q, sel_q;
  logic valid_stage, desel_stage;

  // read result presence for the current cycle
  assign valid_stage = pipe_en ? rd_q : cmd.rd;
  // dual-cycle release rides the read stage only when that stage exists
  assign desel_stage = (dcd_en && pipe_en) ? desel_q : cmd.desel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      desel_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      rd_q    <= cmd.rd;
      desel_q <= cmd.desel;
      if (desel_stage || cmd.wr)
        sel_q <= 1'b0;
      else if (valid_stage)
        sel_q <= 1'b1;
    end
  end

  always_comb begin
    drv_en = !oe_n && !cmd.wr && !desel_stage && (valid_stage || sel_q);
  end

  // R4: single-cycle release cuts the drivers in the deselect cycle
  a_r4_scd_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (!dcd_en && cmd.desel) |-> !drv_en);

  // R5: dual-cycle release in registered mode, off one cycle after deselect
  a_r5_dcd_late: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && dcd_en && pipe_en && $past(cmd.desel)) |-> !drv_en);

  // R6: never drive against a write
  a_r6_wr_off: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.wr |-> !drv_en);

  // R7: drive persists through idle cycles
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(drv_en) && !oe_n && !cmd.wr && !cmd.desel
     && !(dcd_en && pipe_en && $past(cmd.desel))) |-> drv_en);
endmodule

// File: rtl/rdo_data_path.sv
module rdo_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_en,
  input  logic              rd,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] out_q;

  // output register; in flow-through mode it only holds the last word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_q <= '0;
    else if (rd)
      out_q <= arr_data;
  end

  always_comb begin
    if (!pipe_en && rd)
      dout = arr_data;
    else
      dout = out_q;
  end

  // R2: registered mode presents the previous cycle's array word
  a_r2_pipe_word: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pipe_en && $past(rd)) |-> (dout == $past(arr_data)));
endmodule

// File: rtl/rdo_stage.sv
module rdo_stage
  import rdo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_en,
  input  logic              dcd_en,
  input  logic              cmd_rd,
  input  logic              cmd_desel,
  input  logic              cmd_wr,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dout,
  output logic              drv_en
);
  rdo_cmd_t cmd;
  assign cmd = '{rd: cmd_rd, desel: cmd_desel, wr: cmd_wr};

  rdo_drive_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .pipe_en(pipe_en),
    .dcd_en (dcd_en),
    .cmd    (cmd),
    .oe_n   (oe_n),
    .drv_en (drv_en)
  );

  rdo_data_path #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pipe_en (pipe_en),
    .rd      (cmd_rd),
    .arr_data(arr_data),
    .dout    (dout)
  );

  // R3: output enable high keeps drivers off
  a_r3_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drv_en);

  // R1: flow-through drives the array word in its own cycle
  a_r1_ft_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_en && cmd_rd && drv_en) |-> (dout == arr_data));
endmodule

// File: tb/rdo_stage_tb.sv
module rdo_stage_tb;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_en = 1'b1, dcd_en = 1'b0;
  logic cmd_rd = 1'b0, cmd_desel = 1'b0, cmd_wr = 1'b0, oe_n = 1'b1;
  logic [DW-1:0] arr_data = '0;
  logic [DW-1:0] dout;
  logic drv_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // requirement model state
  bit m_prev_rd, m_prev_ds, m_on;
  logic [DW-1:0] m_word;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  rdo_stage #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .dcd_en(dcd_en),
    .cmd_rd(cmd_rd), .cmd_desel(cmd_desel), .cmd_wr(cmd_wr), .oe_n(oe_n),
    .arr_data(arr_data), .dout(dout), .drv_en(drv_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (pipe=%0d dcd=%0d)",
               req, what, act, exp, pipe_en, dcd_en);
    end
  endtask

  task automatic do_reset(input bit p, input bit d);
    @(negedge clk);
    rst_n = 1'b0; pipe_en = p; dcd_en = d;
    cmd_rd = 0; cmd_desel = 0; cmd_wr = 0; oe_n = 0; arr_data = '0;
    #2;
    chk("R8", {7'b0, drv_en}, 8'h00, "drv_en in reset");
    chk("R8", dout, 8'h00, "dout in reset");
    @(negedge clk);
    rst_n = 1'b1;
    m_prev_rd = 0; m_prev_ds = 0; m_on = 0; m_word = '0;
  endtask

  // one cycle: drive at falling edge, compare just before rising edge
  task automatic step(input bit rd, input bit ds, input bit wr, input bit oen,
                      input logic [DW-1:0] d);
    bit valid, dsl, e_drv;
    logic [DW-1:0] e_word;
    string tag;
    @(negedge clk);
    cmd_rd = rd; cmd_desel = ds; cmd_wr = wr; oe_n = oen; arr_data = d;
    valid = pipe_en ? m_prev_rd : rd;
    dsl   = (dcd_en && pipe_en) ? m_prev_ds : ds;
    e_word = (!pipe_en && rd) ? d : m_word;
    e_drv = !oen && !wr && !dsl && (valid || m_on);
    if (wr) tag = "R6";
    else if (oen) tag = "R3";
    else if (dsl || ds) tag = (dcd_en && pipe_en) ? "R5" : "R4";
    else if (valid) tag = pipe_en ? "R2" : "R1";
    else tag = "R7";
    #3;
    chk(tag, {7'b0, drv_en}, {7'b0, e_drv}, "drv_en");
    if (e_drv) chk(tag, dout, e_word, "dout");
    if (dsl || wr) m_on = 0;
    else if (valid) m_on = 1;
    if (rd) m_word = d;
    m_prev_rd = rd; m_prev_ds = ds;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int mode = 0; mode < 4; mode++) begin
      do_reset(mode[0], mode[1]);
      // directed: burst read, idle hold, deselect release
      step(1,0,0,0,8'h11); step(1,0,0,0,8'h22); step(0,0,0,0,8'hEE);
      step(0,0,0,0,8'hEE); step(0,1,0,0,8'hEE); step(0,0,0,0,8'hEE);
      step(0,0,0,0,8'hEE);
      // read then immediate deselect
      step(1,0,0,0,8'h5A); step(0,1,0,0,8'h00); step(0,0,0,0,8'h00);
      // read then write turnaround
      step(1,0,0,0,8'hC3); step(0,0,1,0,8'h00); step(0,0,0,0,8'h00);
      // output enable toggling while selected
      step(1,0,0,0,8'h77); step(0,0,0,1,8'h00); step(0,0,0,0,8'h00);
      step(0,1,0,0,8'h00); step(0,0,0,0,8'h00);
      // pseudo-random command stream
      for (int i = 0; i < 600; i++) begin
        bit r, s, w;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r = (lfsr[2:0] < 3'd4);
        s = (lfsr[2:0] == 3'd4);
        w = (lfsr[2:0] == 3'd5);
        step(r, s, w, (lfsr[7:4] == 4'd0), lfsr[15:8]);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule